// File: doc/BRIEF.md
# Dual-Tap Power-of-Two Clock Prescaler

This block is the shared rate source for a serial unit. A single free-running counter runs on the peripheral clock. From it the block produces two independent enable strobes, each one cycle wide and in the same clock domain. Downstream baud generators and channel logic use these strobes as clock enables. Each tap divides the peripheral clock by 2^n, where n is a 4-bit code held in its own field of a 16-bit control register.

Software writes the control register either as a full 16-bit word or through the low byte lane alone. Only the low byte holds state: the upper byte always reads as zero, and anything written to it is dropped. While any serial channel is running, the channel-busy input is high and every write to the register is ignored. This prevents a ratio change from disturbing a transfer in progress. When a code changes, the counter is not restarted. The new ratio applies from the next counter value that qualifies for it.

Top module: `presc_dual_tap`

## Requirements
- R1: During and right after reset, the control register reads 0x0000 and the shared counter is 0, so both strobes are high.
- R2: Control bits 3:0 hold the code for strobe `tick0`, and bits 7:4 hold the code for `tick1`. The two taps are set independently.
- R3: For a code n, the strobe has a period of exactly 2^n peripheral-clock cycles and is high for one cycle per period. For n = 0 it is high on every cycle.
- R4: The shared counter is 15 bits wide. It starts at 0 at reset and adds 1 each cycle, wrapping at 2^15. For n ≥ 1, a strobe is high exactly when the counter's low n bits are all ones, so the first pulse comes 2^n − 1 cycles after reset is released.
- R5: A write with `wr_be` = 2'b11 while not busy loads bits 7:0 from `wr_data[7:0]` on the next clock edge. Bits 15:8 of the data are discarded.
- R6: A write with `wr_be` = 2'b01 while not busy loads bits 7:0 from `wr_data[7:0]` and leaves no other visible bit changed.
- R7: A write with `wr_be` = 2'b10 leaves the register unchanged.
- R8: No write of any kind changes the register while `busy` is high.
- R9: `rd_data[15:8]` always reads 0.
- R10: Changing a code does not restart the counter. The new ratio applies at the next counter value whose low n bits are all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte-lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| wr_data | input | 16 | Register write data |
| busy | input | 1 | High while any serial channel is enabled; blocks writes |
| rd_data | output | 16 | Current register contents |
| tick0 | output | 1 | Operation-clock enable strobe 0 |
| tick1 | output | 1 | Operation-clock enable strobe 1 |

## Verification
The bench measures the spacing between pulses for every one of the 16 codes on both taps. A decoder that compares against the wrong number of counter bits would produce periods off by a factor of two, and one that treats code 0 as a divider would drop the every-cycle strobe. It tries upper-lane-only writes, mixed writes while busy, and writes that carry junk in the upper byte. A lane decode that is swapped or a lock that leaks would show up as a changed read value or a different strobe rate. A reference counter that keeps running across code changes catches a design that clears its counter on a write, because the phase of the first pulse after the change would then move.

// File: rtl/presc_pkg.sv
package presc_pkg;
    // Width of one divide-code field.
    localparam int unsigned SEL_W_DEF   = 4;
    // Number of independent strobe taps.
    localparam int unsigned NUM_TAPS_DEF = 2;
    // Width of the host-visible control register.
    localparam int unsigned REG_W_DEF   = 16;
    // The counter must cover the largest code: 2^SEL_W - 1 bits.
    localparam int unsigned CNT_W_DEF   = (1 << SEL_W_DEF) - 1;
    // Byte-lane width of the write port.
    localparam int unsigned LANE_W      = 8;
endpackage

// File: rtl/presc_ctrl_reg.sv
module presc_ctrl_reg
    import presc_pkg::*;
#(
    parameter int unsigned SEL_W    = SEL_W_DEF,
    parameter int unsigned NUM_TAPS = NUM_TAPS_DEF,
    parameter int unsigned REG_W    = REG_W_DEF,
    localparam int unsigned FIELD_W = SEL_W * NUM_TAPS,
    localparam int unsigned LANES   = REG_W / LANE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [LANES-1:0]   wr_be,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               busy,
    output logic [FIELD_W-1:0] sel_o,
    output logic [REG_W-1:0]   rd_data
);
    typedef struct packed {
        logic [FIELD_W-1:0] sel;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    // Next-state: only implemented bits are stored; lock while busy.
    always_comb begin
        st_d = st_q;
        if (wr_en && !busy) begin
            for (int i = 0; i < FIELD_W; i++) begin
                if (wr_be[i / LANE_W]) begin
                    st_d.sel[i] = wr_data[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Unimplemented bits read back as zero.
    always_comb begin
        rd_data = '0;
        rd_data[FIELD_W-1:0] = st_q.sel;
    end

    assign sel_o = st_q.sel;
endmodule

// File: rtl/presc_counter.sv
module presc_counter
    import presc_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    // Free-running; wraps naturally at 2^CNT_W.
    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/presc_tap.sv
module presc_tap
    import presc_pkg::*;
#(
    parameter int unsigned SEL_W = SEL_W_DEF,
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] mask;

    // Thermometer mask of the low sel_i bits; code 0 gives an empty mask,
    // which makes the strobe permanently high.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            mask[i] = (SEL_W'(i) < sel_i);
        end
    end

    assign tick_o = ((cnt_i & mask) == mask);
endmodule

// File: rtl/presc_dual_tap.sv
module presc_dual_tap
    import presc_pkg::*;
#(
    parameter int unsigned SEL_W    = SEL_W_DEF,
    parameter int unsigned NUM_TAPS = NUM_TAPS_DEF,
    parameter int unsigned REG_W    = REG_W_DEF,
    localparam int unsigned CNT_W   = (1 << SEL_W) - 1,
    localparam int unsigned FIELD_W = SEL_W * NUM_TAPS,
    localparam int unsigned LANES   = REG_W / LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LANES-1:0] wr_be,
    input  logic [REG_W-1:0] wr_data,
    input  logic             busy,
    output logic [REG_W-1:0] rd_data,
    output logic             tick0,
    output logic             tick1
);
    logic [FIELD_W-1:0]  sel;
    logic [CNT_W-1:0]    cnt;
    logic [NUM_TAPS-1:0] ticks;

    presc_ctrl_reg #(
        .SEL_W    (SEL_W),
        .NUM_TAPS (NUM_TAPS),
        .REG_W    (REG_W)
    ) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .busy    (busy),
        .sel_o   (sel),
        .rd_data (rd_data)
    );

    presc_counter #(
        .CNT_W (CNT_W)
    ) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (cnt)
    );

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        presc_tap #(
            .SEL_W (SEL_W),
            .CNT_W (CNT_W)
        ) i_tap (
            .sel_i  (sel[t*SEL_W +: SEL_W]),
            .cnt_i  (cnt),
            .tick_o (ticks[t])
        );
    end

    assign tick0 = ticks[0];
    assign tick1 = ticks[NUM_TAPS-1];
endmodule

// File: rtl/presc_dual_tap_chk.sv
module presc_dual_tap_chk
    import presc_pkg::*;
#(
    parameter int unsigned SEL_W    = SEL_W_DEF,
    parameter int unsigned NUM_TAPS = NUM_TAPS_DEF,
    parameter int unsigned REG_W    = REG_W_DEF,
    localparam int unsigned FIELD_W = SEL_W * NUM_TAPS,
    localparam int unsigned LANES   = REG_W / LANE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [LANES-1:0] wr_be,
    input logic [REG_W-1:0] wr_data,
    input logic             busy,
    input logic [REG_W-1:0] rd_data,
    input logic             tick0,
    input logic             tick1
);
    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:FIELD_W] == '0);

    // R8
    busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> $stable(rd_data));

    // R6
    low_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && wr_be[0]) |=> (rd_data[FIELD_W-1:0] == $past(wr_data[FIELD_W-1:0])));

    // R7
    high_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && !wr_be[0]) |=> $stable(rd_data));

    // R3
    full_rate0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[SEL_W-1:0] == '0) |-> tick0);

    // R3
    full_rate1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[2*SEL_W-1:SEL_W] == '0) |-> tick1);

    // R3
    gap0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick0 && rd_data[SEL_W-1:0] != '0 && !wr_en) |=> !tick0);

    // R3
    gap1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick1 && rd_data[2*SEL_W-1:SEL_W] != '0 && !wr_en) |=> !tick1);
endmodule

bind presc_dual_tap presc_dual_tap_chk #(
    .SEL_W    (SEL_W),
    .NUM_TAPS (NUM_TAPS),
    .REG_W    (REG_W)
) i_chk (.*);

// File: tb/test_presc_dual_tap.sv
module test_presc_dual_tap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0000;
    logic        busy = 1'b0;
    logic [15:0] rd_data;
    logic        tick0, tick1;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    string cur_req = "R4";

    // Behavioural reference: counter value and register contents.
    int         m_cnt = 0;
    logic [7:0] m_reg = 8'h00;

    always #2 clk = ~clk;

    presc_dual_tap i_presc_dual_tap (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .busy    (busy),
        .rd_data (rd_data),
        .tick0   (tick0),
        .tick1   (tick1)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic bit exp_tick(input int cnt, input int code);
        int p;
        p = 1 << code;
        return (cnt % p) == (p - 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0;
            m_reg <= 8'h00;
        end else begin
            m_cnt <= (m_cnt + 1) % 32768;
            if (wr_en && !busy && wr_be[0]) m_reg <= wr_data[7:0];
        end
    end

    // Per-cycle comparison against the reference.
    always @(negedge clk) begin
        if (rst_n) begin
            check(rd_data == {8'h00, m_reg}, cur_req, rd_data, {8'h00, m_reg});
            check(tick0 == exp_tick(m_cnt, int'(m_reg[3:0])), cur_req, tick0,
                  exp_tick(m_cnt, int'(m_reg[3:0])));
            check(tick1 == exp_tick(m_cnt, int'(m_reg[7:4])), cur_req, tick1,
                  exp_tick(m_cnt, int'(m_reg[7:4])));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 195000) begin
            n_bad++;
            $display("FAIL watchdog (all): actual=%0d expected<=195000", cycles);
            finish_run();
        end
    end

    task automatic wr(input logic [1:0] be, input logic [15:0] d, input logic b);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d; busy = b;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00; wr_data = 16'h0000;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Measure spacing between two consecutive pulses on each tap.
    task automatic measure(input int c0, input int c1, input string req);
        int last0 = 0, last1 = 0, per0 = -1, per1 = -1;
        bit seen0 = 0, seen1 = 0;
        int lim;
        lim = (2 << ((c0 > c1) ? c0 : c1)) + 4;
        for (int cyc = 0; cyc < lim; cyc++) begin
            @(negedge clk);
            if (tick0) begin
                if (seen0 && per0 < 0) per0 = cyc - last0;
                seen0 = 1; last0 = cyc;
            end
            if (tick1) begin
                if (seen1 && per1 < 0) per1 = cyc - last1;
                seen1 = 1; last1 = cyc;
            end
        end
        check(per0 == (1 << c0), req, per0, 1 << c0);
        check(per1 == (1 << c1), req, per1, 1 << c1);
    endtask

    initial begin
        // R1: reset state
        idle(2);
        check(rd_data == 16'h0000, "R1", rd_data, 0);
        check(tick0 && tick1, "R1", {tick0, tick1}, 2'b11);
        @(negedge clk) rst_n = 1'b1;

        // R4: phase from reset with a non-zero code
        cur_req = "R4";
        wr(2'b01, 16'h0032, 1'b0);
        idle(40);

        // R2: independent taps
        cur_req = "R2";
        wr(2'b11, 16'h0053, 1'b0);
        check(rd_data == 16'h0053, "R2", rd_data, 16'h0053);
        measure(3, 5, "R2");

        // R5: full write, upper byte discarded
        cur_req = "R5";
        wr(2'b11, 16'hA5C3, 1'b0);
        check(rd_data == 16'h00C3, "R5", rd_data, 16'h00C3);

        // R6: low-lane write
        cur_req = "R6";
        wr(2'b01, 16'hFF21, 1'b0);
        check(rd_data == 16'h0021, "R6", rd_data, 16'h0021);

        // R7: upper-lane-only write is ignored
        cur_req = "R7";
        wr(2'b10, 16'h1234, 1'b0);
        check(rd_data == 16'h0021, "R7", rd_data, 16'h0021);
        measure(1, 2, "R7");

        // R8: writes ignored while busy
        cur_req = "R8";
        wr(2'b11, 16'h0077, 1'b1);
        check(rd_data == 16'h0021, "R8", rd_data, 16'h0021);
        wr(2'b01, 16'h0000, 1'b1);
        check(rd_data == 16'h0021, "R8", rd_data, 16'h0021);
        measure(1, 2, "R8");
        busy = 1'b0;

        // R9: upper read bits stay zero after all-ones write
        cur_req = "R9";
        wr(2'b11, 16'hFFFF, 1'b0);
        check(rd_data[15:8] == 8'h00, "R9", rd_data, 16'h00FF);

        // R10: code changes mid-stream; reference counter keeps running
        cur_req = "R10";
        wr(2'b01, 16'h0024, 1'b0);
        idle(7);
        wr(2'b01, 16'h0036, 1'b0);
        idle(130);

        // R3: every code on both taps
        cur_req = "R3";
        for (int n = 0; n < 16; n++) begin
            wr(2'b01, 16'(n * 17), 1'b0);
            measure(n, n, "R3");
        end

        finish_run();
    end
endmodule